// File: doc/BRIEF.md
# Dual-Channel Byte Framer for a Shared UART Line

This block sits in front of a UART transmitter and lets two logical sources share its single byte stream. A narrow source carries 7-bit values and a wide source carries full 8-bit values. Each source has its own valid/ready handshake and its own enable. The framer presents one wire byte at a time to the transmitter over a byte valid/ready interface.

A narrow value goes out as one byte with its top bit clear. A wide value is split into two tagged nibble bytes, low nibble first. The tags have the top bit set, so a receiver can tell them apart from narrow bytes on the same line. While the second nibble is owed, the framer reports busy and refuses both sources. It then sends that nibble as soon as the transmitter accepts a byte. When both sources request in the same cycle, the narrow source wins.

A block-level enable gates the whole framer. Dropping it, like reset, discards a half-sent wide value, so the next transfer starts from a clean state.

Top module: `dual_chan_byte_framer`

## Requirements
- R1: A narrow transfer is sent as a single wire byte: bit 7 is 0 and bits 6..0 are the narrow payload.
- R2: A wide transfer first sends the byte {2'b10, 2'b00, payload[3:0]}: bits 7..6 hold the tag 10, bits 5..4 hold the channel-select field 00, and bits 3..0 hold the low nibble.
- R3: In the cycle after a wide request is accepted, busy is 1 and the transmitter is offered {2'b11, 2'b00, payload[7:4]} with tx_valid high. This happens whatever the source requests are.
- R4: While busy is 1, narrow_ready and wide_ready are both 0.
- R5: When both sources are enabled and valid while the framer is not busy, the narrow byte is presented and wide_ready is 0.
- R6: A source whose enable is 0 has ready 0, and its request is not presented on the transmitter port.
- R7: The high nibble sent in the second byte is the value of wide_data when the request was accepted. Later changes to wide_data have no effect on it.
- R8: While blk_en is 0, tx_valid, narrow_ready and wide_ready are 0. Dropping blk_en while busy clears busy, so the next wide transfer starts with its low-nibble byte.
- R9: After reset, busy is 0, and tx_valid is 0 when no request is pending.
- R10: While tx_ready is 0, no source is accepted. A pending second nibble stays offered until tx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_en | input | 1 | Framer enable; low clears the pending nibble |
| narrow_en | input | 1 | Narrow source enable |
| narrow_valid | input | 1 | Narrow request valid |
| narrow_data | input | 7 | Narrow payload |
| narrow_ready | output | 1 | Narrow request accepted when valid |
| wide_en | input | 1 | Wide source enable |
| wide_valid | input | 1 | Wide request valid |
| wide_data | input | 8 | Wide payload |
| wide_ready | output | 1 | Wide request accepted when valid |
| tx_valid | output | 1 | Wire byte offered to the transmitter |
| tx_data | output | 8 | Wire byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| busy | output | 1 | Second nibble of a wide transfer still owed |

## Verification
The bench targets a narrow request that arrives while the second nibble is owed. A design that let the request through would split a wide value on the line. It also changes wide_data right after acceptance: a design that did not capture the payload would send a wrong high nibble. Simultaneous requests expose reversed priority, which shows up as a wide tag byte where a narrow byte belongs. Stalls of tx_ready and drops of blk_en in mid-transfer catch a nibble that is lost, sent twice, or left stale after re-enable.

// File: rtl/framer_pkg.sv
package framer_pkg;
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_NARROW = 2'd1,
      SRC_WIDE   = 2'd2,
      SRC_UPPER  = 2'd3
   } src_e;

   localparam logic [1:0] TAG_LOW  = 2'b10;
   localparam logic [1:0] TAG_HIGH = 2'b11;
endpackage

// File: rtl/framer_arbiter.sv
module framer_arbiter #(
   parameter bit NARROW_FIRST = 1'b1
) (
   input  logic              open_i,
   input  logic              pend_i,
   input  logic              n_en_i,
   input  logic              n_req_i,
   input  logic              w_en_i,
   input  logic              w_req_i,
   output framer_pkg::src_e  src_o,
   output logic              n_ready_o,
   output logic              w_ready_o
);
   import framer_pkg::*;

   generate
      if (NARROW_FIRST) begin : g_narrow_first
         always_comb begin
            if (pend_i)       src_o = SRC_UPPER;
            else if (n_req_i) src_o = SRC_NARROW;
            else if (w_req_i) src_o = SRC_WIDE;
            else              src_o = SRC_NONE;
         end
         assign n_ready_o = open_i & n_en_i;
         assign w_ready_o = open_i & w_en_i & ~n_req_i;
      end else begin : g_wide_first
         always_comb begin
            if (pend_i)       src_o = SRC_UPPER;
            else if (w_req_i) src_o = SRC_WIDE;
            else if (n_req_i) src_o = SRC_NARROW;
            else              src_o = SRC_NONE;
         end
         assign w_ready_o = open_i & w_en_i;
         assign n_ready_o = open_i & n_en_i & ~w_req_i;
      end
   endgenerate
endmodule

// File: rtl/framer_encoder.sv
module framer_encoder #(
   parameter int BYTE_W = 8
) (
   input  framer_pkg::src_e    src_i,
   input  logic [BYTE_W-2:0]   n_data_i,
   input  logic [BYTE_W/2-1:0] w_low_i,
   input  logic [BYTE_W/2-1:0] hold_high_i,
   output logic [BYTE_W-1:0]   byte_o
);
   import framer_pkg::*;
   localparam int NIB_W  = BYTE_W / 2;
   localparam int CSEL_W = NIB_W - 2;

   always_comb begin
      case (src_i)
         SRC_NARROW: byte_o = {1'b0, n_data_i};
         SRC_WIDE:   byte_o = {TAG_LOW,  {CSEL_W{1'b0}}, w_low_i};
         SRC_UPPER:  byte_o = {TAG_HIGH, {CSEL_W{1'b0}}, hold_high_i};
         default:    byte_o = '0;
      endcase
   end
endmodule

// File: rtl/dual_chan_byte_framer.sv
module dual_chan_byte_framer #(
   parameter int BYTE_W       = 8,
   parameter bit NARROW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en,
   input  logic              narrow_en,
   input  logic              narrow_valid,
   input  logic [BYTE_W-2:0] narrow_data,
   output logic              narrow_ready,
   input  logic              wide_en,
   input  logic              wide_valid,
   input  logic [BYTE_W-1:0] wide_data,
   output logic              wide_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              busy
);
   import framer_pkg::*;
   localparam int NIB_W = BYTE_W / 2;

   generate
      if (BYTE_W % 2 != 0 || BYTE_W < 6) begin : g_bad_width
         $error("BYTE_W must be even and at least 6");
      end
   endgenerate

   logic             pend_q;
   logic [NIB_W-1:0] hold_q;
   logic             n_req, w_req, open_gate;
   src_e             src;

   assign n_req     = blk_en & narrow_en & narrow_valid;
   assign w_req     = blk_en & wide_en & wide_valid;
   assign open_gate = blk_en & tx_ready & ~pend_q;

   framer_arbiter #(.NARROW_FIRST(NARROW_FIRST)) i_arb (
      .open_i   (open_gate),
      .pend_i   (pend_q & blk_en),
      .n_en_i   (narrow_en),
      .n_req_i  (n_req),
      .w_en_i   (wide_en),
      .w_req_i  (w_req),
      .src_o    (src),
      .n_ready_o(narrow_ready),
      .w_ready_o(wide_ready)
   );

   framer_encoder #(.BYTE_W(BYTE_W)) i_enc (
      .src_i      (src),
      .n_data_i   (narrow_data),
      .w_low_i    (wide_data[NIB_W-1:0]),
      .hold_high_i(hold_q),
      .byte_o     (tx_data)
   );

   assign tx_valid = blk_en & (src != SRC_NONE);
   assign busy     = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (!blk_en) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (tx_ready) pend_q <= 1'b0;
      end else if (wide_valid && wide_ready) begin
         pend_q <= 1'b1;
         hold_q <= wide_data[BYTE_W-1:NIB_W];
      end
   end

   assert_no_ready_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!narrow_ready && !wide_ready));
   assert_upper_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_valid && wide_ready) |=> (busy && tx_valid == blk_en));
   assert_upper_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && blk_en) |-> (tx_valid && tx_data[BYTE_W-1:BYTE_W-2] == 2'b11));
   assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({narrow_valid && narrow_ready, wide_valid && wide_ready}));
   assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && blk_en && !tx_ready) |=> busy);
   assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en |-> (!tx_valid && !narrow_ready && !wide_ready));
endmodule

// File: tb/test_dual_chan_byte_framer.sv
module test_dual_chan_byte_framer;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n, blk_en, narrow_en, narrow_valid, wide_en, wide_valid, tx_ready;
   logic [6:0] narrow_data;
   logic [7:0] wide_data;
   logic       narrow_ready, wide_ready, tx_valid, busy;
   logic [7:0] tx_data;

   int checks = 0;
   int errors = 0;

   bit       m_pend = 1'b0;
   bit [3:0] m_hold = '0;

   always #(CLK_P/2) clk = ~clk;

   dual_chan_byte_framer i_dual_chan_byte_framer (
      .clk(clk), .rst_n(rst_n), .blk_en(blk_en),
      .narrow_en(narrow_en), .narrow_valid(narrow_valid), .narrow_data(narrow_data),
      .narrow_ready(narrow_ready),
      .wide_en(wide_en), .wide_valid(wide_valid), .wide_data(wide_data),
      .wide_ready(wide_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .busy(busy)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One cycle: compare outputs with the model, then advance the model at the edge.
   task automatic cyc(string req);
      bit n_el, w_el, e_v, e_nr, e_wr, nxt_p;
      bit [7:0] e_d;
      bit [3:0] nxt_h;
      #1;
      n_el = blk_en && narrow_en && narrow_valid;
      w_el = blk_en && wide_en && wide_valid;
      e_v  = blk_en && (m_pend || n_el || w_el);
      e_nr = blk_en && !m_pend && narrow_en && tx_ready;
      e_wr = blk_en && !m_pend && wide_en && tx_ready && !n_el;
      if (m_pend)    e_d = {4'b1100, m_hold};
      else if (n_el) e_d = {1'b0, narrow_data};
      else           e_d = {4'b1000, wide_data[3:0]};
      chk(req, "tx_valid", tx_valid, e_v);
      chk(req, "narrow_ready", narrow_ready, e_nr);
      chk(req, "wide_ready", wide_ready, e_wr);
      chk(req, "busy", busy, m_pend);
      if (e_v) chk(req, "tx_data", tx_data, e_d);
      nxt_p = m_pend; nxt_h = m_hold;
      if (!blk_en) nxt_p = 1'b0;
      else if (m_pend) begin
         if (tx_ready) nxt_p = 1'b0;
      end else if (wide_valid && e_wr) begin
         nxt_p = 1'b1; nxt_h = wide_data[7:4];
      end
      @(posedge clk);
      m_pend = nxt_p; m_hold = nxt_h;
      @(negedge clk);
   endtask

   task automatic idle();
      narrow_valid = 0; wide_valid = 0; narrow_en = 1; wide_en = 1; blk_en = 1; tx_ready = 1;
   endtask

   initial begin
      #(CLK_P*150000);
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 0; idle(); narrow_data = '0; wide_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc("R9");                                    // reset state

      // R1: narrow bytes
      foreach (narrow_data[i]) begin
         narrow_valid = 1; narrow_data = 7'(1 << i) ^ 7'h55; cyc("R1");
      end
      narrow_data = 7'h7F; cyc("R1");
      narrow_valid = 0;

      // R2 and R3: wide transfers
      for (int k = 0; k < 3; k++) begin
         wide_valid = 1; wide_data = (k == 0) ? 8'hA5 : (k == 1) ? 8'h0F : 8'hF0;
         cyc("R2");
         wide_valid = 0; cyc("R3");
      end

      // R7 and R4: payload changes and narrow request during pending nibble
      wide_valid = 1; wide_data = 8'h3C; cyc("R7");
      wide_data = 8'hD2; narrow_valid = 1; narrow_data = 7'h11; cyc("R4");
      wide_valid = 0; cyc("R1");
      narrow_valid = 0;

      // R5: simultaneous requests
      narrow_valid = 1; narrow_data = 7'h2A; wide_valid = 1; wide_data = 8'h96; cyc("R5");
      narrow_valid = 0; cyc("R2"); wide_valid = 0; cyc("R3");

      // R10: stall during pending nibble
      wide_valid = 1; wide_data = 8'h7E; cyc("R2");
      wide_valid = 0; tx_ready = 0; cyc("R10"); cyc("R10");
      narrow_valid = 1; cyc("R10");
      tx_ready = 1; cyc("R3"); narrow_valid = 0; cyc("R9");

      // R6: channel enables off
      narrow_en = 0; narrow_valid = 1; cyc("R6");
      wide_valid = 1; wide_data = 8'h5B; cyc("R6");
      wide_en = 0; narrow_en = 1; cyc("R6");
      wide_en = 1; narrow_valid = 0; wide_valid = 0; cyc("R6");

      // R8: drop block enable while pending
      wide_valid = 1; wide_data = 8'hC3; cyc("R2");
      wide_valid = 0; blk_en = 0; narrow_valid = 1; cyc("R8");
      blk_en = 1; narrow_valid = 0; cyc("R8");
      wide_valid = 1; wide_data = 8'h81; cyc("R8");
      wide_valid = 0; cyc("R3");

      // Mixed traffic
      for (int n = 0; n < 400; n++) begin
         narrow_valid = $urandom_range(0, 1); narrow_data = 7'($urandom);
         wide_valid = $urandom_range(0, 1);   wide_data = 8'($urandom);
         narrow_en = ($urandom_range(0, 7) != 0); wide_en = ($urandom_range(0, 7) != 0);
         tx_ready = ($urandom_range(0, 3) != 0); blk_en = ($urandom_range(0, 15) != 0);
         cyc("R5");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule